// File: doc/BRIEF.md
# Sequential Signed/Unsigned Divider with Divide-Error Detection

This block divides a double-width dividend by a single-width divisor, one quotient bit per clock. The operand width is chosen per operation: a quarter, a half or the whole of the `OW` parameter. With the default `OW = 32` these are 8, 16 and 32 bits. A per-operation input selects unsigned or two's-complement arithmetic. The dividend arrives as two halves, an upper word and a lower word. Each result is the quotient and the remainder at the selected width.

The unit reports a divide error instead of a result in two cases. The first is a divisor that is zero at the selected width. The second is a quotient whose magnitude does not fit the result range. On an error the result and flag outputs keep their earlier values. On success the unit also updates a small status-flag word: carry, sign, parity and auxiliary. The surrounding logic supplies the incoming flag word with each operation.

A controller pulses `start_i` while the unit is idle. It then waits for the single-cycle `done_o` pulse and reads `div_err_o` together with the results.

Top module: `div_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `div_err_o`, `quot_o`, `rem_o` and `flags_o` are all zero.
- R2: `width_i` selects the operand width w: 0 selects OW/4, 1 selects OW/2, and 2 or 3 selects OW. Only the low w bits of `dvd_hi_i`, `dvd_lo_i` and `divisor_i` are used, and the dividend is {dvd_hi_i[w-1:0], dvd_lo_i[w-1:0]}. The bits of `quot_o` and `rem_o` above w are zero.
- R3: With `signed_i` low, a successful divide gives the quotient floor(dividend/divisor) and the remainder dividend mod divisor.
- R4: With `signed_i` high, the operands are two's complement at widths 2w and w. The quotient truncates toward zero, and the remainder takes the sign of the dividend (zero stays zero).
- R5: A divisor whose low w bits are all zero is reported on the first rising edge after the accepting edge, with `done_o` and `div_err_o` both high. `busy_o` never rises for that operation, and the result and flag outputs are unchanged.
- R6: A range error is raised when the true quotient exceeds 2^(w-1)-1 in magnitude (signed, so -2^(w-1) also faults) or exceeds 2^w-1 (unsigned). It is reported with `done_o` and `div_err_o` at the normal latency, and the result and flag outputs are unchanged.
- R7: For a nonzero divisor, `done_o` rises on the (w+2)-th rising edge after the edge that accepts `start_i`.
- R8: `busy_o` is high from the accepting edge until the edge that raises `done_o`. `done_o` lasts exactly one cycle.
- R9: `start_i` is ignored while `busy_o` is high. The running operation's result and timing are unaffected, and no extra `done_o` follows.
- R10: On success, `flags_o` bit 0 (carry) and bit 3 (sign) are 0. Bit 1 (parity) is 1 exactly when `rem_o[7:0]` holds an even number of ones.
- R11: On success, `flags_o` bit 2 (auxiliary) is 0 at full width OW. At narrower widths it copies `flags_i[2]` as sampled on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| signed_i | input | 1 | 1 = two's-complement divide, 0 = unsigned |
| width_i | input | 2 | Operand width select |
| dvd_hi_i | input | OW | Upper half of the dividend |
| dvd_lo_i | input | OW | Lower half of the dividend |
| divisor_i | input | OW | Divisor |
| flags_i | input | 4 | Incoming flag word (bit 2 used) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Divide error, valid with done_o |
| quot_o | output | OW | Quotient, zero-extended above w |
| rem_o | output | OW | Remainder, zero-extended above w |
| flags_o | output | 4 | Flag word: carry, parity, auxiliary, sign |

## Verification
The bound checker watches the handshake on every cycle. It checks the one-cycle error response to a zero divisor and that `busy_o` stays low for it. It also checks that `done_o` is a single pulse that closes every busy period, that an error never appears without completion, and that results and flags are frozen in the error cycle. It checks carry, sign and parity on every successful completion as well.

The arithmetic itself can only be shown by the bench's scenarios. That covers quotient and remainder values under each width and sign mode, truncation toward zero, and the exact range boundaries such as -2^(w-1) and 2^w-1. The bench also shows that upper operand bits are ignored and that a start during a running divide is dropped.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic [1:0] {
      DW_QTR  = 2'd0,
      DW_HALF = 2'd1,
      DW_FULL = 2'd2,
      DW_ALT  = 2'd3
   } dw_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } div_st_e;

   localparam int FLAG_W   = 4;
   localparam int FB_CARRY = 0;
   localparam int FB_PAR   = 1;
   localparam int FB_AUX   = 2;
   localparam int FB_SIGN  = 3;
endpackage

// File: rtl/div_prep.sv
// Operand preparation: width masking, sign extraction, magnitudes,
// zero-divisor and early range detection.
module div_prep
   import div_pkg::*;
#(
   parameter  int OW = 32,
   localparam int CW = $clog2(OW) + 2,
   localparam int DW = 2 * OW
) (
   input  logic [1:0]    sel_i,
   input  logic          sgn_i,
   input  logic [OW-1:0] hi_i,
   input  logic [OW-1:0] lo_i,
   input  logic [OW-1:0] dvs_i,
   output logic [CW-1:0] w_o,
   output logic [DW-1:0] dvd_mag_o,
   output logic [OW-1:0] dvs_mag_o,
   output logic          dvd_neg_o,
   output logic          dvs_neg_o,
   output logic          dvs_zero_o,
   output logic          pre_ovf_o
);
   logic [OW-1:0] wmask, smask, hm, lm, dm, dvs_ext;
   logic [DW-1:0] dvd_raw, dvd_ext;

   always_comb begin
      unique case (dw_sel_e'(sel_i))
         DW_QTR:  w_o = CW'(OW / 4);
         DW_HALF: w_o = CW'(OW / 2);
         default: w_o = CW'(OW);
      endcase
   end

   assign wmask = {OW{1'b1}} >> (OW - int'(w_o));
   assign smask = wmask & ~(wmask >> 1);          // sign bit at width w
   assign hm    = hi_i & wmask;
   assign lm    = lo_i & wmask;
   assign dm    = dvs_i & wmask;

   assign dvd_neg_o  = sgn_i & (|(hm & smask));
   assign dvs_neg_o  = sgn_i & (|(dm & smask));
   assign dvs_zero_o = (dm == '0);

   assign dvd_raw   = ({{OW{1'b0}}, hm} << w_o) | {{OW{1'b0}}, lm};
   assign dvd_ext   = dvd_neg_o ? (dvd_raw | ({DW{1'b1}} << (2 * int'(w_o)))) : dvd_raw;
   assign dvd_mag_o = dvd_neg_o ? (~dvd_ext + DW'(1)) : dvd_ext;

   assign dvs_ext   = dvs_neg_o ? (dm | ({OW{1'b1}} << w_o)) : dm;
   assign dvs_mag_o = dvs_neg_o ? (~dvs_ext + OW'(1)) : dvs_ext;

   // quotient would need more than w+1 bits
   assign pre_ovf_o = (dvd_mag_o >> (int'(w_o) + 1)) >= {{OW{1'b0}}, dvs_mag_o};
endmodule

// File: rtl/div_core.sv
// Bit-serial restoring divider: shifted divisor against a split
// high/low partial remainder, one quotient bit per clock, MSB first.
module div_core #(
   parameter  int OW        = 32,
   parameter  bit SPLIT_SUB = 1'b1,
   localparam int CW        = $clog2(OW) + 2,
   localparam int DW        = 2 * OW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] w_i,
   input  logic [DW-1:0] dvd_mag_i,
   input  logic [OW-1:0] dvs_mag_i,
   output logic          act_o,
   output logic          last_o,
   output logic [OW:0]   q_mag_o,
   output logic [OW-1:0] r_mag_o
);
   logic [DW-1:0] rem_q, sdv_q, diff;
   logic [OW:0]   q_q;
   logic [CW-1:0] cnt_q;
   logic          act_q, take;

   generate
      if (SPLIT_SUB) begin : g_split
         logic [OW:0] lo_d, hi_d;
         assign lo_d = {1'b0, rem_q[OW-1:0]} - {1'b0, sdv_q[OW-1:0]};
         assign hi_d = {1'b0, rem_q[DW-1:OW]} - {1'b0, sdv_q[DW-1:OW]}
                       - {{OW{1'b0}}, lo_d[OW]};
         assign take = ~hi_d[OW];
         assign diff = {hi_d[OW-1:0], lo_d[OW-1:0]};
      end else begin : g_flat
         logic [DW:0] full_d;
         assign full_d = {1'b0, rem_q} - {1'b0, sdv_q};
         assign take   = ~full_d[DW];
         assign diff   = full_d[DW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         sdv_q <= '0;
         q_q   <= '0;
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (load_i) begin
         rem_q <= dvd_mag_i;
         sdv_q <= {{OW{1'b0}}, dvs_mag_i} << w_i;
         q_q   <= '0;
         cnt_q <= w_i;
         act_q <= 1'b1;
      end else if (act_q) begin
         if (take) rem_q <= diff;
         q_q   <= {q_q[OW-1:0], take};
         sdv_q <= sdv_q >> 1;
         if (cnt_q == '0) act_q <= 1'b0;
         else             cnt_q <= cnt_q - CW'(1);
      end
   end

   assign act_o   = act_q;
   assign last_o  = act_q && (cnt_q == '0);
   assign q_mag_o = q_q;
   assign r_mag_o = rem_q[OW-1:0];
endmodule

// File: rtl/div_fix.sv
// Sign correction, range check and flag formation.
module div_fix
   import div_pkg::*;
#(
   parameter  int OW = 32,
   localparam int CW = $clog2(OW) + 2
) (
   input  logic [OW:0]       q_mag_i,
   input  logic [OW-1:0]     r_mag_i,
   input  logic [CW-1:0]     w_i,
   input  logic              sgn_i,
   input  logic              dvd_neg_i,
   input  logic              dvs_neg_i,
   input  logic              pre_ovf_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [OW-1:0]     quot_o,
   output logic [OW-1:0]     rem_o,
   output logic [FLAG_W-1:0] flags_o,
   output logic              range_err_o
);
   logic [OW-1:0] wmask, q_lo;
   logic [OW:0]   lim;

   assign wmask = {OW{1'b1}} >> (OW - int'(w_i));
   assign lim   = {(OW+1){1'b1}} >> (OW + 1 - int'(w_i) + (sgn_i ? 1 : 0));
   assign q_lo  = q_mag_i[OW-1:0];

   assign quot_o = ((dvd_neg_i ^ dvs_neg_i) ? (~q_lo + OW'(1)) : q_lo) & wmask;
   assign rem_o  = (dvd_neg_i ? (~r_mag_i + OW'(1)) : r_mag_i) & wmask;

   assign range_err_o = pre_ovf_i | (q_mag_i > lim);

   always_comb begin
      flags_o           = flags_i;
      flags_o[FB_CARRY] = 1'b0;
      flags_o[FB_SIGN]  = 1'b0;
      flags_o[FB_PAR]   = ~^rem_o[7:0];
      if (int'(w_i) == OW) flags_o[FB_AUX] = 1'b0;
   end
endmodule

// File: rtl/div_unit.sv
module div_unit
   import div_pkg::*;
#(
   parameter int OW        = 32,
   parameter bit SPLIT_SUB = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          signed_i,
   input  logic [1:0]    width_i,
   input  logic [OW-1:0] dvd_hi_i,
   input  logic [OW-1:0] dvd_lo_i,
   input  logic [OW-1:0] divisor_i,
   input  logic [3:0]    flags_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          div_err_o,
   output logic [OW-1:0] quot_o,
   output logic [OW-1:0] rem_o,
   output logic [3:0]    flags_o
);
   localparam int CW = $clog2(OW) + 2;
   localparam int DW = 2 * OW;

   generate
      if (OW < 8 || (OW % 4) != 0) begin : g_bad_ow
         $error("div_unit: OW must be a multiple of 4 and at least 8");
      end
   endgenerate

   div_st_e           st_q;
   logic [CW-1:0]     w_nx, w_q;
   logic [DW-1:0]     dvd_mag;
   logic [OW-1:0]     dvs_mag, fx_quot, fx_rem;
   logic              dvd_neg, dvs_neg, dvs_zero, pre_ovf;
   logic              sgn_q, dvd_neg_q, dvs_neg_q, pre_ovf_q;
   logic [FLAG_W-1:0] fin_q, fx_flags;
   logic              core_act, core_last, core_load, fx_err;
   logic [OW:0]       q_mag;
   logic [OW-1:0]     r_mag;

   div_prep #(.OW(OW)) u_prep (
      .sel_i      (width_i),
      .sgn_i      (signed_i),
      .hi_i       (dvd_hi_i),
      .lo_i       (dvd_lo_i),
      .dvs_i      (divisor_i),
      .w_o        (w_nx),
      .dvd_mag_o  (dvd_mag),
      .dvs_mag_o  (dvs_mag),
      .dvd_neg_o  (dvd_neg),
      .dvs_neg_o  (dvs_neg),
      .dvs_zero_o (dvs_zero),
      .pre_ovf_o  (pre_ovf)
   );

   assign core_load = (st_q == ST_IDLE) && start_i && !dvs_zero;

   div_core #(.OW(OW), .SPLIT_SUB(SPLIT_SUB)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (core_load),
      .w_i       (w_nx),
      .dvd_mag_i (dvd_mag),
      .dvs_mag_i (dvs_mag),
      .act_o     (core_act),
      .last_o    (core_last),
      .q_mag_o   (q_mag),
      .r_mag_o   (r_mag)
   );

   div_fix #(.OW(OW)) u_fix (
      .q_mag_i     (q_mag),
      .r_mag_i     (r_mag),
      .w_i         (w_q),
      .sgn_i       (sgn_q),
      .dvd_neg_i   (dvd_neg_q),
      .dvs_neg_i   (dvs_neg_q),
      .pre_ovf_i   (pre_ovf_q),
      .flags_i     (fin_q),
      .quot_o      (fx_quot),
      .rem_o       (fx_rem),
      .flags_o     (fx_flags),
      .range_err_o (fx_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         done_o    <= 1'b0;
         div_err_o <= 1'b0;
         quot_o    <= '0;
         rem_o     <= '0;
         flags_o   <= '0;
         w_q       <= '0;
         sgn_q     <= 1'b0;
         dvd_neg_q <= 1'b0;
         dvs_neg_q <= 1'b0;
         pre_ovf_q <= 1'b0;
         fin_q     <= '0;
      end else begin
         done_o    <= 1'b0;
         div_err_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (dvs_zero) begin
                     done_o    <= 1'b1;
                     div_err_o <= 1'b1;
                  end else begin
                     st_q      <= ST_RUN;
                     w_q       <= w_nx;
                     sgn_q     <= signed_i;
                     dvd_neg_q <= dvd_neg;
                     dvs_neg_q <= dvs_neg;
                     pre_ovf_q <= pre_ovf;
                     fin_q     <= flags_i;
                  end
               end
            end
            ST_RUN: begin
               if (core_last) st_q <= ST_FIN;
            end
            ST_FIN: begin
               st_q   <= ST_IDLE;
               done_o <= 1'b1;
               if (fx_err) begin
                  div_err_o <= 1'b1;
               end else begin
                  quot_o  <= fx_quot;
                  rem_o   <= fx_rem;
                  flags_o <= fx_flags;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q != ST_IDLE) || core_act;
endmodule

// File: rtl/div_unit_chk.sv
module div_unit_chk #(
   parameter int OW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic [1:0]    width_i,
   input logic [OW-1:0] divisor_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          div_err_o,
   input logic [OW-1:0] quot_o,
   input logic [OW-1:0] rem_o,
   input logic [3:0]    flags_o
);
   logic [OW-1:0] dmask;
   logic          zero_req;

   always_comb begin
      case (width_i)
         2'd0:    dmask = {OW{1'b1}} >> (OW - OW / 4);
         2'd1:    dmask = {OW{1'b1}} >> (OW - OW / 2);
         default: dmask = {OW{1'b1}};
      endcase
   end

   assign zero_req = start_i && !busy_o && ((divisor_i & dmask) == '0);

   AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      zero_req |=> (done_o && div_err_o));                              // R5
   AST_ZERO_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      zero_req |=> !busy_o);                                             // R5
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      div_err_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(flags_o))); // R6
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      div_err_o |-> done_o);                                             // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                               // R8
   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);                                         // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);                                               // R8
   AST_OK_CARRY_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !div_err_o) |-> (!flags_o[0] && !flags_o[3]));          // R10
   AST_OK_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !div_err_o) |-> (flags_o[1] == ~^rem_o[7:0]));         // R10
endmodule

bind div_unit div_unit_chk #(.OW(OW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .width_i   (width_i),
   .divisor_i (divisor_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .div_err_o (div_err_o),
   .quot_o    (quot_o),
   .rem_o     (rem_o),
   .flags_o   (flags_o)
);

// File: tb/tb_div_unit.sv
module tb_div_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        signed_i = 1'b0;
   logic [1:0]  width_i = 2'd0;
   logic [31:0] dvd_hi_i = '0, dvd_lo_i = '0, divisor_i = '0;
   logic [3:0]  flags_i = '0;
   logic        busy_o, done_o, div_err_o;
   logic [31:0] quot_o, rem_o;
   logic [3:0]  flags_o;

   int tests = 0, fails = 0;
   bit ended = 0;
   logic [31:0] m_q = '0, m_r = '0;
   logic [3:0]  m_f = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   div_unit dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
      .width_i(width_i), .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i),
      .divisor_i(divisor_i), .flags_i(flags_i), .busy_o(busy_o),
      .done_o(done_o), .div_err_o(div_err_o), .quot_o(quot_o),
      .rem_o(rem_o), .flags_o(flags_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_tb();
      if (!ended) begin
         ended = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // Reference model from the requirements (R2, R3, R4, R6, R10, R11)
   task automatic ref_model(input logic [31:0] hi, lo, dv, input logic sg,
                            input logic [1:0] wc, input logic [3:0] fin,
                            output int w, output bit zero, output bit err,
                            output logic [31:0] q, output logic [31:0] r,
                            output logic [3:0] f);
      logic [63:0] mask, m2, h, l, d, dvd, dmag, vmag, qm, rm, lim, qx, rx;
      bit dneg, vneg;
      w    = (wc == 2'd0) ? 8 : (wc == 2'd1) ? 16 : 32;
      mask = (w == 32) ? 64'hFFFF_FFFF : ((64'd1 << w) - 1);
      m2   = (w == 32) ? '1 : ((64'd1 << (2*w)) - 1);
      h = {32'd0, hi} & mask; l = {32'd0, lo} & mask; d = {32'd0, dv} & mask;
      zero = (d == 0);
      err  = zero;
      q = '0; r = '0; f = '0;
      if (!zero) begin
         dvd  = (h << w) | l;
         dneg = sg && h[w-1];
         vneg = sg && d[w-1];
         dmag = dneg ? ((~dvd + 1) & m2) : dvd;
         vmag = vneg ? ((~d + 1) & mask) : d;
         qm   = dmag / vmag;
         rm   = dmag % vmag;
         lim  = sg ? ((64'd1 << (w-1)) - 1) : mask;
         err  = (qm > lim);
         qx   = (dneg ^ vneg) ? ((~qm + 1) & mask) : qm;
         rx   = dneg ? ((~rm + 1) & mask) : rm;
         q = qx[31:0]; r = rx[31:0];
         f = fin; f[0] = 1'b0; f[3] = 1'b0; f[1] = ~^rx[7:0];
         if (w == 32) f[2] = 1'b0;
      end
   endtask

   task automatic run_op(input logic [31:0] hi, lo, dv, input logic sg,
                         input logic [1:0] wc, input logic [3:0] fin, input bit inject);
      int w, n;
      bit zero, err;
      logic [31:0] eq, er;
      logic [3:0] ef;
      ref_model(hi, lo, dv, sg, wc, fin, w, zero, err, eq, er, ef);
      @(negedge clk);
      dvd_hi_i = hi; dvd_lo_i = lo; divisor_i = dv; signed_i = sg;
      width_i = wc; flags_i = fin; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 1;
      check(zero ? "R5 busy stays low" : "R8 busy after accept", busy_o, zero ? 0 : 1);
      while (!done_o && n < 100) begin
         if (inject && n == 3) begin
            start_i = 1'b1; divisor_i = '0; dvd_hi_i = ~hi; flags_i = ~fin;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start_i = 1'b0;
      check(zero ? "R5 latency" : "R7 latency", n, zero ? 1 : w + 3);
      check(zero ? "R5 error" : "R6 error", div_err_o, err);
      if (!err) begin
         m_q = eq; m_r = er; m_f = ef;
      end
      check(sg ? "R4 quotient" : "R3 quotient", quot_o, m_q);
      check(sg ? "R4 remainder" : "R3 remainder", rem_o, m_r);
      check(w == 32 ? "R10 R11 flags full" : "R10 R11 flags narrow", flags_o, m_f);
      if (inject) begin
         @(negedge clk); @(negedge clk);
         check("R9 no extra done", done_o, 0);
         check("R9 result kept", quot_o, m_q);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      tests++; fails++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
      finish_tb();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 busy", busy_o, 0);
      check("R1 done", done_o, 0);
      check("R1 err", div_err_o, 0);
      check("R1 quot", quot_o, 0);
      check("R1 rem", rem_o, 0);
      check("R1 flags", flags_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      run_op(32'h0000_0000, 32'h0000_1234, 32'h0000_0056, 0, 2'd1, 4'h0, 0); // R3 16-bit
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'h0000_0002, 1, 2'd0, 4'h4, 0); // R4 -7/2 -> -3 r -1
      run_op(32'hAB00_00FF, 32'h1200_0000, 32'h5500_0002, 1, 2'd0, 4'h0, 0); // R6 -256/2=-128 faults, R2 upper bits
      run_op(32'h0000_0000, 32'h0000_00FE, 32'h0000_0002, 1, 2'd0, 4'h4, 0); // R4 127 fits, R11 aux kept
      run_op(32'h0000_0000, 32'hCD00_00FF, 32'h0000_0001, 0, 2'd0, 4'h0, 0); // R3 255 fits unsigned
      run_op(32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 0, 2'd0, 4'h0, 0); // R6 256 faults unsigned
      run_op(32'h1234_5678, 32'h9ABC_DEF0, 32'hFFFF_0000, 0, 2'd1, 4'h0, 0); // R5 zero at 16 bits
      run_op(32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_0001, 0, 2'd1, 4'h0, 0); // R6 large early overflow
      run_op(32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1, 2'd2, 4'h0, 0); // R6 min / -1
      run_op(32'h0000_0003, 32'h8765_4321, 32'h0000_0010, 0, 2'd3, 4'h4, 0); // R2 code 3 full, R11 aux cleared
      run_op(32'hFFFF_FFFF, 32'h0000_0001, 32'h7FFF_FFFF, 1, 2'd2, 4'hF, 0); // R4 full signed
      run_op(32'h0000_0010, 32'h0000_0100, 32'h0000_1000, 0, 2'd1, 4'h4, 1); // R9 start while busy

      // constrained random
      for (int i = 0; i < 400; i++) begin
         logic [1:0]  wc;
         logic [31:0] hi, lo, dv, mask;
         logic        sg;
         int          w;
         wc = 2'($urandom % 4);
         sg = 1'($urandom % 2);
         w  = (wc == 2'd0) ? 8 : (wc == 2'd1) ? 16 : 32;
         mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
         dv = $urandom;
         if ($urandom % 16 == 0) dv = dv & ~mask;
         lo = $urandom;
         case ($urandom % 4)
            0: hi = $urandom;
            1: hi = 32'd0;
            2: hi = 32'hFFFF_FFFF;
            default: hi = ($urandom % ((dv & mask) | 32'd1)) >> 1;
         endcase
         hi = (hi & mask) | ($urandom & ~mask);
         run_op(hi, lo, dv, sg, wc, 4'($urandom), (i % 50) == 7);
      end
      finish_tb();
   end
endmodule